// File: doc/BRIEF.md
# Inbound interrupt message forwarder

This block sits between an inbound link and the system-bus side of a host bridge. Every memory write from the link enters through a valid/ready port. If the posted-write buffer has room in that cycle, the write is taken. If it has no room, the block answers with a retry in the same cycle, and the source must send the write again later. An interrupt write uses the same port and gets the same flow control as any other write.

The address is decoded only after a write has been posted, at the head of the buffer. A write whose top twelve address bits are 0xFEE (0xFEE0_0000 up to 0xFEEF_FFFF) leaves as an interrupt message transaction. Every other write leaves as a plain memory write. The type tag travels with the address, data and byte enables. Entries leave in the order they were taken.

Top module: `irq_msg_fwd`

## Requirements
- R1: An outbound transaction whose address lies in 0xFEE0_0000..0xFEEF_FFFF carries out_kind = 1 (interrupt message). Any other address, including 0xFEDF_FFFF and 0xFEF0_0000, carries out_kind = 0 (memory write).
- R2: An inbound write gets the same ready/retry answer whether or not its address is in the interrupt window.
- R3: While the buffer holds fewer than DEPTH entries, a valid inbound write sees in_ready = 1 and in_retry = 0, and it is accepted on that clock edge.
- R4: While the buffer holds DEPTH entries and no entry leaves in that cycle, a valid inbound write sees in_retry = 1 and in_ready = 0 in that same cycle. The write is discarded and never appears on the outbound port.
- R5: Outbound address, data and byte enables equal those of the accepted write. out_valid rises the cycle after a write enters an empty buffer.
- R6: Transactions leave in strict acceptance order.
- R7: A write arriving while the buffer is full, in a cycle where out_valid and out_ready are both 1, is accepted without a retry.
- R8: After reset, out_valid = 0, in_ready = 1 and in_retry = 0.
- R9: While out_valid = 1 and out_ready = 0, the outbound address, data, byte enables and tag stay unchanged and out_valid stays high.
- R10: With the outbound side stalled, exactly DEPTH writes (4 by default) are accepted before the first retry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound write request |
| in_addr | input | AW (32) | Inbound write address |
| in_data | input | DW (32) | Inbound write data |
| in_be | input | DW/8 (4) | Inbound byte enables |
| in_ready | output | 1 | Write is taken on this edge |
| in_retry | output | 1 | Write refused, resend later |
| out_valid | output | 1 | Outbound transaction available |
| out_ready | input | 1 | System side takes the transaction |
| out_kind | output | 1 | 0 = memory write, 1 = interrupt message |
| out_addr | output | AW (32) | Outbound address |
| out_data | output | DW (32) | Outbound data |
| out_be | output | DW/8 (4) | Outbound byte enables |

## Verification
The assertions assume that inputs are steady across each clock edge. They also assume that out_ready may depend on nothing the block drives later in the same cycle. The bench drives every input half a cycle away from the rising edge and samples just before it. It sets out_ready from its own schedule, never from out_valid, so the combinational path from out_ready to in_ready is never part of a loop. Retried writes are resent only when the bench wants them. Otherwise they are dropped from the expected queue, which matches the rule that a refused write is not stored.

// File: rtl/ifwd_pkg.sv
`timescale 1ns/1ps
package ifwd_pkg;
    typedef enum logic {
        XK_MEMWR  = 1'b0,
        XK_INTMSG = 1'b1
    } xact_kind_e;
endpackage

// File: rtl/ifwd_classify.sv
`timescale 1ns/1ps
module ifwd_classify
    import ifwd_pkg::*;
#(
    parameter int AW       = 32,
    parameter int WIN_BITS = 12,
    parameter logic [WIN_BITS-1:0] WIN_TAG = 12'hFEE
) (
    input  logic [AW-1:0] addr,
    output xact_kind_e    kind
);
    localparam int LSB = AW - WIN_BITS;

    always_comb begin
        kind = (addr[AW-1:LSB] == WIN_TAG) ? XK_INTMSG : XK_MEMWR;
    end
endmodule

// File: rtl/ifwd_fifo.sv
`timescale 1ns/1ps
module ifwd_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 68
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        if (pop)  st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wp] <= wdata;
    end

    assign rdata = mem_q[st_q.rp];
    assign full  = (st_q.cnt == CMAX);
    assign empty = (st_q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop)); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CMAX); // R10
endmodule

// File: rtl/irq_msg_fwd.sv
`timescale 1ns/1ps
module irq_msg_fwd
    import ifwd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [AW-1:0]   in_addr,
    input  logic [DW-1:0]   in_data,
    input  logic [DW/8-1:0] in_be,
    output logic            in_ready,
    output logic            in_retry,
    output logic            out_valid,
    input  logic            out_ready,
    output logic            out_kind,
    output logic [AW-1:0]   out_addr,
    output logic [DW-1:0]   out_data,
    output logic [DW/8-1:0] out_be
);
    localparam int BEW = DW / 8;
    localparam int PLW = AW + DW + BEW;

    logic           buf_full, buf_empty, buf_push, buf_pop;
    logic [PLW-1:0] buf_wdata, buf_rdata;
    xact_kind_e     head_kind;

    assign out_valid = !buf_empty;
    assign buf_pop   = out_valid && out_ready;
    assign in_ready  = !buf_full || buf_pop;
    assign in_retry  = in_valid && !in_ready;
    assign buf_push  = in_valid && in_ready;
    assign buf_wdata = {in_addr, in_data, in_be};

    ifwd_fifo #(.DEPTH(DEPTH), .WIDTH(PLW)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (buf_push),
        .wdata (buf_wdata),
        .pop   (buf_pop),
        .rdata (buf_rdata),
        .full  (buf_full),
        .empty (buf_empty)
    );

    assign {out_addr, out_data, out_be} = buf_rdata;

    ifwd_classify #(.AW(AW)) u_cls (
        .addr (out_addr),
        .kind (head_kind)
    );

    assign out_kind = head_kind;

    AST_RETRY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && buf_full && !out_ready) |-> in_retry); // R4
    AST_ROOM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !buf_full) |-> !in_retry); // R3
    AST_POP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && buf_full && out_valid && out_ready) |-> !in_retry); // R7
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_addr, out_data, out_be, out_kind}))); // R9
    AST_FIRST_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_retry && !out_valid) |=> out_valid); // R5
endmodule

// File: tb/sim_irq_msg_fwd.sv
`timescale 1ns/1ps
module sim_irq_msg_fwd;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_be = '0;
    logic        in_ready, in_retry, out_valid, out_kind;
    logic        out_ready = 1'b0;
    logic [31:0] out_addr, out_data;
    logic [3:0]  out_be;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [68:0] exp_q [$];

    always #2 clk = ~clk;

    irq_msg_fwd #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data), .in_be(in_be),
        .in_ready(in_ready), .in_retry(in_retry),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_addr(out_addr), .out_data(out_data), .out_be(out_be)
    );

    function automatic logic in_window(logic [31:0] a);
        return (a >= 32'hFEE0_0000) && (a <= 32'hFEEF_FFFF);
    endfunction

    task automatic chk(string req, logic [68:0] act, logic [68:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: presents a write, checks the answer, records accepted writes
    task automatic send(logic [31:0] a, logic [31:0] d, logic [3:0] be, bit exp_retry, string req);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d; in_be = be;
        #1.5;
        chk(req, {67'd0, in_retry, in_ready}, {67'd0, exp_retry, !exp_retry});
        if (!exp_retry) exp_q.push_back({in_window(a), a, d, be});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: compares every outbound transfer against the reference queue
    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected output", {out_kind, out_addr, out_data, out_be}, '0);
                end else begin
                    chk("R1/R5/R6 outbound item", {out_kind, out_addr, out_data, out_be}, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] held_addr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1.5;
        // R8 reset state
        chk("R8 reset", {66'd0, out_valid, in_ready, in_retry}, {66'd0, 3'b010});

        // R1 R5 R6: streaming with boundary addresses
        out_ready = 1'b1;
        send(32'hFEDF_FFFF, 32'h1111_0001, 4'hF, 1'b0, "R3 stream");
        send(32'hFEE0_0000, 32'h1111_0002, 4'h1, 1'b0, "R3 stream");
        send(32'hFEEF_FFFF, 32'h1111_0003, 4'h3, 1'b0, "R3 stream");
        send(32'hFEF0_0000, 32'h1111_0004, 4'hC, 1'b0, "R3 stream");
        send(32'h0000_1000, 32'h1111_0005, 4'h8, 1'b0, "R3 stream");
        send(32'hFEE1_2340, 32'h1111_0006, 4'hF, 1'b0, "R3 stream");
        idle(4);
        chk("R6 drained", {68'd0, exp_q.size() == 0}, 69'd1);

        // R5: out_valid rises the cycle after entering empty buffer
        out_ready = 1'b0;
        send(32'h2000_0000, 32'hAAAA_0000, 4'hF, 1'b0, "R3 first");
        @(negedge clk);
        in_valid = 1'b0;
        #1.5;
        chk("R5 out_valid after one edge", {68'd0, out_valid}, 69'd1);
        held_addr = out_addr;

        // R10: fill to DEPTH with output stalled (one already inside)
        send(32'hFEE0_0010, 32'hAAAA_0001, 4'h1, 1'b0, "R10 fill");
        send(32'h2000_0008, 32'hAAAA_0002, 4'h2, 1'b0, "R10 fill");
        send(32'hFEEF_0000, 32'hAAAA_0003, 4'h4, 1'b0, "R10 fill");
        // R4 R2: full, both interrupt and memory writes retried
        send(32'hFEE0_0020, 32'hBAD0_0001, 4'hF, 1'b1, "R4 R2 irq retry");
        send(32'h3000_0000, 32'hBAD0_0002, 4'hF, 1'b1, "R4 R2 mem retry");
        idle(3);
        // R9: head held during stall
        chk("R9 hold", {37'd0, out_addr}, {37'd0, held_addr});
        chk("R9 valid held", {68'd0, out_valid}, 69'd1);

        // R7: pop while full accepts the incoming write
        @(negedge clk);
        out_ready = 1'b1;
        in_valid = 1'b1; in_addr = 32'hFEEA_BCD0; in_data = 32'hCAFE_0007; in_be = 4'h5;
        #1.5;
        chk("R7 pop-while-full", {67'd0, in_retry, in_ready}, {67'd0, 2'b01});
        exp_q.push_back({in_window(in_addr), in_addr, in_data, in_be});
        idle(8);
        chk("R4 R6 retried writes absent, queue drained", {68'd0, exp_q.size() == 0}, 69'd1);
        chk("R3 empty after drain", {67'd0, out_valid, in_ready}, {67'd0, 2'b01});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule